// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other over a set of numbered channels. Each channel carries one occupied flag per direction. It does not store any message payload. Each processor has its own register bank on a shared 32-bit register bus.

To post a message, a processor sets its own outgoing flag for a channel. Before doing so, it reads its outgoing status: a set bit means the channel is busy and the processor must not send. The receiving processor learns of the message by reading the sender's status register, one bank stride away from its own. After consuming the message, the receiver acknowledges it by writing a clear bit into its own control register. That write drops the flag in the sender's status.

Each processor has two interrupts:
- A receive interrupt, a level that stays high while any unmasked incoming flag is set.
- A transmit-free interrupt, a one-cycle pulse raised when one of its unmasked outgoing flags is cleared.

A read-only configuration word reports how many channels exist. The channel count is a parameter from 1 to 16.

Top module: `mbx_flag_ctrl`

## Requirements
- R1: After reset, both status registers read 0, both interrupt mask registers read all ones over the implemented channel bits (rx bits n, tx bits 16+n), and all four interrupt outputs are low.
- R2: Writing 1 to bit 16+n of processor p's control register (byte address p*0x10+0x8) sets bit n of p's status register (byte address p*0x10+0xC) on the next clock edge.
- R3: Writing 1 to bit n of processor p's control register clears bit n of the other processor's status register on the next clock edge. Flags in p's own status are left unchanged.
- R4: Control bits written as 0 have no effect on any flag, and the control register always reads 0.
- R5: Both status registers can be read at any time through the single bus, so either processor can read the status of either direction.
- R6: The configuration word at byte address 0x3F0 reads the channel count in bits 7:0 and zero above. Writes to it are ignored.
- R7: Set, clear and mask bits for channels at or above the channel count are ignored, and those bit positions read as zero.
- R8: Processor p's mask register sits at byte address p*0x10+0x4 and is read/write. Bit n set to 1 disables the receive interrupt for incoming channel n. Bit 16+n set to 1 disables the transmit-free interrupt for outgoing channel n.
- R9: rx_irq[p] is high exactly while some flag in the other processor's status is set and its rx mask bit in p's mask register is 0.
- R10: txfree_irq[p] is high for exactly one cycle, in the cycle after the clock edge at which an outgoing flag of p with tx mask bit 0 is cleared. A flag whose tx mask bit is 1 raises no pulse.
- R11: Reads of any unmapped or unaligned address return zero. Writes to such addresses, and writes to the status registers, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, takes effect at the next rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| rx_irq | output | 2 | Per-processor receive interrupt (level) |
| txfree_irq | output | 2 | Per-processor transmit-free interrupt (one-cycle pulse) |

## Verification
The assertions assume the bus carries at most one access per cycle. A set and a clear can therefore never target the same flag in the same cycle. The set-wins priority in the flag bank is kept for safety, but the bus cannot reach it. The assertions also assume that addr, wr_en and wdata hold known values whenever the block is out of reset. The stimulus respects both assumptions by changing the bus only on falling clock edges, one access per task call, with wr_en dropped between writes. Interrupt and read-back checks are timed to the cycle after the single flag register and the single pulse register update.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int NPROC    = 2;
   localparam int MAX_CH   = 16;
   localparam int TX_SHIFT = 16;
   localparam logic [3:0] OFS_MASK = 4'h4;
   localparam logic [3:0] OFS_CTL  = 4'h8;
   localparam logic [3:0] OFS_STAT = 4'hC;
   localparam logic [11:0] CFG_ADDR = 12'h3F0;
endpackage

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
   parameter int NUM_CH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] occ_o
);
   // set takes priority over clear for the same flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ_o <= '0;
      else        occ_o <= set_i | (occ_o & ~clr_i);
   end

   p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((occ_o & $past(set_i)) == $past(set_i)));

   p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((occ_o & $past(clr_i & ~set_i)) == '0));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(occ_o));
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
   import mbx_pkg::*;
#(
   parameter int NUM_CH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic [31:0]       wdata,
   input  logic [NUM_CH-1:0] in_occ,
   input  logic [NUM_CH-1:0] out_occ,
   input  logic [NUM_CH-1:0] out_set,
   input  logic [NUM_CH-1:0] out_clr,
   output logic [NUM_CH-1:0] rx_mask_o,
   output logic [NUM_CH-1:0] tx_mask_o,
   output logic              rx_irq_o,
   output logic              txfree_irq_o
);
   logic [NUM_CH-1:0] falling;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_mask_o <= '1;
         tx_mask_o <= '1;
      end else if (mask_we) begin
         rx_mask_o <= wdata[NUM_CH-1:0];
         tx_mask_o <= wdata[TX_SHIFT +: NUM_CH];
      end
   end

   assign falling  = out_occ & out_clr & ~out_set;
   assign rx_irq_o = |(in_occ & ~rx_mask_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) txfree_irq_o <= 1'b0;
      else        txfree_irq_o <= |(falling & ~tx_mask_o);
   end

   p_rx_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq_o |-> (in_occ != '0));

   p_rx_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mask_o == '1) |-> !rx_irq_o);

   p_txfree_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      txfree_irq_o |-> (($past(out_occ) & ~out_occ & ~$past(tx_mask_o)) != '0));
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl
   import mbx_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [1:0]        rx_irq,
   output logic [1:0]        txfree_irq
);
   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("mbx_flag_ctrl: NUM_CH must be 1..16");
      end
      if (ADDR_W < 10) begin : g_bad_aw
         $error("mbx_flag_ctrl: ADDR_W must be at least 10");
      end
   endgenerate

   logic       bank_hit, cfg_hit, bsel;
   logic [3:0] ofs;
   logic [1:0] ctl_we, mask_we;

   logic [NUM_CH-1:0] set_v [NPROC];
   logic [NUM_CH-1:0] clr_v [NPROC];
   logic [NUM_CH-1:0] occ   [NPROC];
   logic [NUM_CH-1:0] rxm   [NPROC];
   logic [NUM_CH-1:0] txm   [NPROC];

   assign bank_hit = (addr[ADDR_W-1:5] == '0) && (addr[1:0] == 2'b00);
   assign cfg_hit  = (addr == ADDR_W'(CFG_ADDR));
   assign bsel     = addr[4];
   assign ofs      = addr[3:0];

   for (genvar p = 0; p < NPROC; p++) begin : g_proc
      assign ctl_we[p]  = wr_en && bank_hit && (bsel == 1'(p)) && (ofs == OFS_CTL);
      assign mask_we[p] = wr_en && bank_hit && (bsel == 1'(p)) && (ofs == OFS_MASK);
   end

   for (genvar p = 0; p < NPROC; p++) begin : g_lane
      // own control sets own flags; the peer's control clears them
      assign set_v[p] = ctl_we[p]       ? wdata[TX_SHIFT +: NUM_CH] : '0;
      assign clr_v[p] = ctl_we[NPROC-1-p] ? wdata[NUM_CH-1:0]        : '0;

      mbx_flag_bank #(.NUM_CH(NUM_CH)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_v[p]),
         .clr_i (clr_v[p]),
         .occ_o (occ[p])
      );

      mbx_irq_unit #(.NUM_CH(NUM_CH)) u_irq (
         .clk          (clk),
         .rst_n        (rst_n),
         .mask_we      (mask_we[p]),
         .wdata        (wdata),
         .in_occ       (occ[NPROC-1-p]),
         .out_occ      (occ[p]),
         .out_set      (set_v[p]),
         .out_clr      (clr_v[p]),
         .rx_mask_o    (rxm[p]),
         .tx_mask_o    (txm[p]),
         .rx_irq_o     (rx_irq[p]),
         .txfree_irq_o (txfree_irq[p])
      );
   end

   always_comb begin
      rdata = '0;
      if (cfg_hit) begin
         rdata[7:0] = 8'(NUM_CH);
      end else if (bank_hit) begin
         case (ofs)
            OFS_MASK: begin
               rdata[NUM_CH-1:0]         = rxm[bsel];
               rdata[TX_SHIFT +: NUM_CH] = txm[bsel];
            end
            OFS_STAT: rdata[NUM_CH-1:0] = occ[bsel];
            default:  rdata = '0;
         endcase
      end
   end

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_hit && !(bank_hit && (ofs == OFS_MASK || ofs == OFS_STAT))) |-> (rdata == '0));

   p_stat_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_hit && ofs == OFS_STAT) |-> ((rdata >> NUM_CH) == '0));

   p_one_ctl_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_we, mask_we}));
endmodule

// File: tb/mbx_flag_ctrl_test.sv
module mbx_flag_ctrl_test;
   localparam int NCH = 12;
   localparam logic [31:0] MFULL = 32'h0FFF_0FFF;

   logic        clk = 0, rst_n = 0, wr_en = 0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic [1:0]  rx_irq, txfree_irq;
   int tests = 0, failed = 0;
   bit done = 0;

   always #10 clk = ~clk;

   mbx_flag_ctrl #(.NUM_CH(NCH), .ADDR_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .rx_irq(rx_irq), .txfree_irq(txfree_irq));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1;
      @(negedge clk); wr_en = 0; wdata = '0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] v);
      @(negedge clk); addr = a; #2 v = rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(12'h00C, v); check("R1 stat0", v, 0);
      rd(12'h01C, v); check("R1 stat1", v, 0);
      rd(12'h004, v); check("R1 mask0", v, MFULL);
      rd(12'h014, v); check("R1 mask1", v, MFULL);
      check("R1 irqs", {30'd0, rx_irq | txfree_irq}, 0);
   endtask

   task automatic t_set_zero;
      logic [31:0] v;
      wr(12'h008, 32'h1 << 19);
      wr(12'h018, 32'h1 << 27);
      rd(12'h00C, v); check("R2 stat0 ch3", v, 32'h8);
      rd(12'h01C, v); check("R5 stat1 ch11", v, 32'h800);
      wr(12'h008, 32'h0);
      rd(12'h00C, v); check("R4 zero write stat0", v, 32'h8);
      rd(12'h01C, v); check("R4 zero write stat1", v, 32'h800);
      rd(12'h008, v); check("R4 ctl reads 0", v, 0);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      wr(12'h018, 32'h8);
      rd(12'h00C, v); check("R3 p1 clears p0 ch3", v, 0);
      rd(12'h01C, v); check("R3 own flags kept", v, 32'h800);
      wr(12'h008, 32'h800);
      rd(12'h01C, v); check("R3 p0 clears p1 ch11", v, 0);
   endtask

   task automatic t_unimpl;
      logic [31:0] v;
      wr(12'h008, 32'hF000_0000);
      rd(12'h00C, v); check("R7 high set bits ignored", v, 0);
      wr(12'h014, 32'hFFFF_FFFF);
      rd(12'h014, v); check("R7 mask high bits zero", v, MFULL);
   endtask

   task automatic t_cfg;
      logic [31:0] v;
      rd(12'h3F0, v); check("R6 cfg", v, NCH);
      wr(12'h3F0, 32'hFF);
      rd(12'h3F0, v); check("R6 cfg write ignored", v, NCH);
   endtask

   task automatic t_rx;
      logic [31:0] v;
      wr(12'h014, 32'h0FFF_0FDF);
      rd(12'h014, v); check("R8 mask readback", v, 32'h0FFF_0FDF);
      wr(12'h008, 32'h1 << 20);
      check("R9 rx1 masked ch4", {30'd0, rx_irq}, 0);
      wr(12'h008, 32'h1 << 21);
      check("R9 rx1 high ch5", {30'd0, rx_irq}, 32'h2);
      wr(12'h018, 32'h20);
      check("R9 rx1 low after clear", {30'd0, rx_irq}, 0);
      wr(12'h018, 32'h10);
      rd(12'h00C, v); check("R3 stat0 empty", v, 0);
   endtask

   task automatic t_txfree;
      wr(12'h004, 32'h0FFB_0FFF);
      wr(12'h008, 32'h1 << 18);
      check("R10 no pulse on set", {30'd0, txfree_irq}, 0);
      wr(12'h018, 32'h4);
      check("R10 pulse", {30'd0, txfree_irq}, 32'h1);
      @(negedge clk);
      check("R10 pulse one cycle", {30'd0, txfree_irq}, 0);
      wr(12'h008, 32'h1 << 23);
      wr(12'h018, 32'h80);
      check("R10 masked no pulse", {30'd0, txfree_irq}, 0);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr(12'h008, 32'h1 << 16);
      rd(12'h020, v); check("R11 read 0x020", v, 0);
      rd(12'h00A, v); check("R11 unaligned read", v, 0);
      rd(12'h3F4, v); check("R11 read 0x3F4", v, 0);
      wr(12'h028, 32'hFFFF_FFFF);
      wr(12'h00B, 32'hFFFF_FFFF);
      wr(12'h00C, 32'h0);
      rd(12'h00C, v); check("R11 writes ignored", v, 32'h1);
      rd(12'h004, v); check("R11 mask untouched", v, 32'h0FFB_0FFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset; t_set_zero; t_clear; t_unimpl; t_cfg; t_rx; t_txfree; t_unmapped;
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         tests++; failed++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, failed);
         $finish;
      end
   end
endmodule